// File: doc/BRIEF.md
# Embedded-Key Match Checker with AXI4-Lite Access

This block holds a 256-bit secret that is fixed in logic when the design is built. Software writes a candidate key as eight 32-bit words through an AXI4-Lite slave, sets a start bit, and later reads a single verdict bit. The verdict is 1 only when all eight candidate words were written since the last comparison and every one of them equals the matching word of the secret. The secret has no read path: it is not reachable through any register, and reads of the candidate words return zero.

A comparison takes a fixed number of cycles, whatever the data. The engine walks the words one per cycle and keeps a sticky mismatch flag. It never leaves early, then pads to the full latency. The engine is a three-state machine. `ST_IDLE` waits for a start. On an accepted start it moves to `ST_SCAN` (transition *launch*). After the last word it moves to `ST_SETTLE` (transition *scan_end*). When the cycle count reaches the latency it returns to `ST_IDLE` (transition *complete*), and that update publishes the verdict and sets the done bit.

Registers, all word-aligned byte offsets:
- Control at 0x000: bit 0 start (write 1, reads 0), bit 1 done, bit 2 idle.
- Candidate words at 0x080 + 4·i, for i = 0..7.
- Verdict at 0x100, in bit 0.

Top module: `keychk_top`

## Requirements
- R1: After reset the control register reads 0x4 (idle set, done clear) and the verdict register reads 0.
- R2: Candidate word i is written at byte offset 0x080 + 4·i and is compared with secret bits [32·i+31 : 32·i]. When all eight words equal the secret, the verdict bit 0 at 0x100 reads 1 after completion.
- R3: If any single candidate word differs from its secret word, even by one bit and at any position, the verdict reads 0.
- R4: Each candidate word has a written flag, and every flag is cleared when a comparison completes. A start with any flag clear yields verdict 0. This covers a missing word, an empty key, and a restart without rewriting the key.
- R5: Done and idle are set on the 34th rising edge after the edge that accepts the start write. A control read whose address is accepted on that 34th edge still returns 0x0. A read accepted one edge later returns 0x6. This holds for every data pattern.
- R6: The done bit clears when the control register is read or when a new start is accepted. The start bit always reads 0.
- R7: A start written while a comparison is busy is ignored and does not move the completion edge. Candidate writes while busy are also ignored.
- R8: Reads of the candidate region, of unmapped offsets and of misaligned addresses return 0. Every read and write response is OKAY (0).
- R9: An accepted start clears the verdict to 0 until that comparison completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | WORD_W | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | WORD_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
Some internal faults leave the done bit at the wrong time: a cycle counter off by one, an early exit on mismatch, or a start accepted while busy. These show up in the control readback at exactly edge 34 or 35 after the start, so each comparison probes both edges. A wrong word index, a lost mismatch flag or an uncleared written flag shows up as a wrong verdict on the very next comparison. The bench sweeps every word position for both a corrupted word and an omitted word. A leak of key storage shows up on the first read of the candidate region.

// File: rtl/keychk_pkg.sv
package keychk_pkg;

    // Byte offsets of the register map
    localparam int OFF_CTRL   = 'h000;
    localparam int OFF_KEY    = 'h080;
    localparam int OFF_RESULT = 'h100;

    // Control register bit positions
    localparam int CTRL_START = 0;
    localparam int CTRL_DONE  = 1;
    localparam int CTRL_IDLE  = 2;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SETTLE
    } eng_state_e;

endpackage

// File: rtl/keychk_secret.sv
// Holds the built-in secret and returns one word selected by index.
module keychk_secret #(
    parameter int                          WORD_W = 32,
    parameter int                          NWORDS = 8,
    parameter logic [NWORDS*WORD_W-1:0]    SECRET = '0,
    localparam int                         IDX_W  = $clog2(NWORDS)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] words [NWORDS];

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        assign words[i] = SECRET[i*WORD_W +: WORD_W];
    end

    assign word = words[idx];

endmodule

// File: rtl/keychk_engine.sv
// Fixed-latency, word-serial compare engine.
module keychk_engine
    import keychk_pkg::*;
#(
    parameter int                       WORD_W  = 32,
    parameter int                       NWORDS  = 8,
    parameter int                       LATENCY = 34,
    parameter logic [NWORDS*WORD_W-1:0] SECRET  = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NWORDS*WORD_W-1:0] key_flat,
    input  logic [NWORDS-1:0]        flags,
    output logic                     busy,
    output logic                     finish,
    output logic                     verdict
);

    localparam int IDX_W = $clog2(NWORDS);
    localparam int CNT_W = $clog2(LATENCY);
    localparam logic [CNT_W-1:0] SCAN_LAST = CNT_W'(NWORDS - 1);
    localparam logic [CNT_W-1:0] RUN_LAST  = CNT_W'(LATENCY - 1);

    eng_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              miss_q;
    logic              full_q;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] secret_word;
    logic [WORD_W-1:0] cand_word;
    logic [WORD_W-1:0] cand_words [NWORDS];

    for (genvar i = 0; i < NWORDS; i++) begin : g_cand
        assign cand_words[i] = key_flat[i*WORD_W +: WORD_W];
    end

    assign idx       = cnt_q[IDX_W-1:0];
    assign cand_word = cand_words[idx];

    keychk_secret #(
        .WORD_W (WORD_W),
        .NWORDS (NWORDS),
        .SECRET (SECRET)
    ) secret_i (
        .idx  (idx),
        .word (secret_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: launch, scan_end, complete
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)             state_d = ST_SCAN;
            ST_SCAN:   if (cnt_q == SCAN_LAST) state_d = ST_SETTLE;
            ST_SETTLE: if (cnt_q == RUN_LAST)  state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        finish  = 1'b0;
        verdict = full_q & ~miss_q;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_SCAN:   busy = 1'b1;
            ST_SETTLE: begin
                busy   = 1'b1;
                finish = (cnt_q == RUN_LAST);
            end
            default:   busy = 1'b0;
        endcase
    end

    // Datapath: counter, sticky mismatch, completeness snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            miss_q <= 1'b0;
            full_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q  <= '0;
                        miss_q <= 1'b0;
                        full_q <= &flags;
                    end
                end
                ST_SCAN: begin
                    cnt_q  <= cnt_q + 1'b1;
                    miss_q <= miss_q | (cand_word != secret_word);
                end
                ST_SETTLE: begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/keychk_regs.sv
// AXI4-Lite slave, candidate storage, control and verdict registers.
module keychk_regs
    import keychk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 32,
    parameter int NWORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        s_awaddr,
    input  logic                     s_awvalid,
    output logic                     s_awready,
    input  logic [WORD_W-1:0]        s_wdata,
    input  logic                     s_wvalid,
    output logic                     s_wready,
    output logic [1:0]               s_bresp,
    output logic                     s_bvalid,
    input  logic                     s_bready,
    input  logic [ADDR_W-1:0]        s_araddr,
    input  logic                     s_arvalid,
    output logic                     s_arready,
    output logic [WORD_W-1:0]        s_rdata,
    output logic [1:0]               s_rresp,
    output logic                     s_rvalid,
    input  logic                     s_rready,
    input  logic                     busy,
    input  logic                     finish,
    input  logic                     verdict,
    output logic                     start,
    output logic [NWORDS*WORD_W-1:0] key_flat,
    output logic [NWORDS-1:0]        flags
);

    localparam int IDX_W = $clog2(NWORDS);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_KEY     = ADDR_W'(OFF_KEY);
    localparam logic [ADDR_W-1:0] A_KEY_END = ADDR_W'(OFF_KEY + 4 * NWORDS);
    localparam logic [ADDR_W-1:0] A_RESULT  = ADDR_W'(OFF_RESULT);

    logic              wr_fire, rd_fire;
    logic              bvalid_q, rvalid_q;
    logic [WORD_W-1:0] rdata_q, rd_mux;
    logic              done_q, result_q;
    logic              wr_ctrl, wr_key, rd_ctrl;
    logic [IDX_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] wr_off;

    function automatic logic in_key(input logic [ADDR_W-1:0] a);
        return (a[1:0] == 2'b00) && (a >= A_KEY) && (a < A_KEY_END);
    endfunction

    // Handshakes: address and data accepted together
    assign wr_fire   = s_awvalid & s_wvalid & (~bvalid_q | s_bready);
    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign rd_fire   = s_arvalid & (~rvalid_q | s_rready);
    assign s_arready = rd_fire;

    assign s_bvalid = bvalid_q;
    assign s_bresp  = RESP_OKAY;
    assign s_rvalid = rvalid_q;
    assign s_rresp  = RESP_OKAY;
    assign s_rdata  = rdata_q;

    // Decode
    assign wr_off  = s_awaddr - A_KEY;
    assign wr_idx  = IDX_W'(wr_off >> 2);
    assign wr_ctrl = wr_fire && (s_awaddr == A_CTRL);
    assign wr_key  = wr_fire && in_key(s_awaddr) && !busy;
    assign rd_ctrl = rd_fire && (s_araddr == A_CTRL);
    assign start   = wr_ctrl && s_wdata[CTRL_START] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bvalid_q <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (wr_fire)       bvalid_q <= 1'b1;
            else if (s_bready) bvalid_q <= 1'b0;
            if (rd_fire) begin
                rvalid_q <= 1'b1;
                rdata_q  <= rd_mux;
            end else if (s_rready) begin
                rvalid_q <= 1'b0;
            end
        end
    end

    // Candidate words and their written flags
    for (genvar i = 0; i < NWORDS; i++) begin : g_key
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                key_flat[i*WORD_W +: WORD_W] <= '0;
                flags[i]                     <= 1'b0;
            end else if (finish) begin
                flags[i] <= 1'b0;
            end else if (wr_key && (wr_idx == IDX_W'(i))) begin
                key_flat[i*WORD_W +: WORD_W] <= s_wdata;
                flags[i]                     <= 1'b1;
            end
        end
    end

    // Done and verdict; completion wins over a same-edge control read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= 1'b0;
        end else begin
            if (finish)       done_q <= 1'b1;
            else if (start)   done_q <= 1'b0;
            else if (rd_ctrl) done_q <= 1'b0;
            if (finish)       result_q <= verdict;
            else if (start)   result_q <= 1'b0;
        end
    end

    // Read mux: the candidate region and the secret never drive read data
    always_comb begin
        rd_mux = '0;
        if (s_araddr == A_CTRL) begin
            rd_mux[CTRL_DONE] = done_q;
            rd_mux[CTRL_IDLE] = ~busy;
        end else if (s_araddr == A_RESULT) begin
            rd_mux[0] = result_q;
        end
    end

endmodule

// File: rtl/keychk_top.sv
module keychk_top #(
    parameter int                       ADDR_W  = 12,
    parameter int                       WORD_W  = 32,
    parameter int                       NWORDS  = 8,
    parameter int                       LATENCY = 34,
    parameter logic [NWORDS*WORD_W-1:0] SECRET  =
        256'h9e37_79b9_7f4a_7c15_f39c_c060_5ced_c834_1082_2767_2b5c_0f11_d1b5_4a32_6a09_e667
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [WORD_W-1:0] s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [WORD_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);

    logic                     eng_start, eng_busy, eng_finish, eng_verdict;
    logic [NWORDS*WORD_W-1:0] key_flat;
    logic [NWORDS-1:0]        key_flags;

    keychk_regs #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .NWORDS (NWORDS)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .busy      (eng_busy),
        .finish    (eng_finish),
        .verdict   (eng_verdict),
        .start     (eng_start),
        .key_flat  (key_flat),
        .flags     (key_flags)
    );

    keychk_engine #(
        .WORD_W  (WORD_W),
        .NWORDS  (NWORDS),
        .LATENCY (LATENCY),
        .SECRET  (SECRET)
    ) engine_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .key_flat (key_flat),
        .flags    (key_flags),
        .busy     (eng_busy),
        .finish   (eng_finish),
        .verdict  (eng_verdict)
    );

endmodule

// File: rtl/keychk_sva.sv
module keychk_sva #(
    parameter int NWORDS  = 8,
    parameter int LATENCY = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              finish,
    input logic              verdict,
    input logic [NWORDS-1:0] flags,
    input logic              bvalid,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic [1:0]        rresp
);

    localparam int RW = $clog2(LATENCY + 1) + 1;

    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R5: a run lasts exactly LATENCY cycles
    assert_latency_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == RW'(LATENCY)));

    // R5 / R7: a run never outlasts the latency (no restart mid-run)
    assert_run_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RW'(LATENCY)));

    // R4: a pass verdict needs every written flag
    assert_pass_needs_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && verdict) |-> (&flags));

    // R4: flags are empty once a run ends
    assert_flags_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (flags == '0));

    // R8: responses are always OKAY
    assert_rresp_okay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rresp == 2'b00));

    assert_bresp_okay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (bresp == 2'b00));

endmodule

bind keychk_top keychk_sva #(
    .NWORDS  (NWORDS),
    .LATENCY (LATENCY)
) sva_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (eng_busy),
    .finish  (eng_finish),
    .verdict (eng_verdict),
    .flags   (key_flags),
    .bvalid  (s_bvalid),
    .bresp   (s_bresp),
    .rvalid  (s_rvalid),
    .rresp   (s_rresp)
);

// File: tb/keychk_top_tb_top.sv
module keychk_top_tb_top;

    localparam logic [255:0] TB_KEY =
        256'h0123_4567_89ab_cdef_fedc_ba98_7654_3210_a5a5_5a5a_c3c3_3c3c_dead_beef_cafe_f00d;
    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_KEY  = 12'h080;
    localparam logic [11:0] A_RES  = 12'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    keychk_top #(.SECRET(TB_KEY)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (awaddr),
        .s_awvalid (awvalid),
        .s_awready (awready),
        .s_wdata   (wdata),
        .s_wvalid  (wvalid),
        .s_wready  (wready),
        .s_bresp   (bresp),
        .s_bvalid  (bvalid),
        .s_bready  (1'b1),
        .s_araddr  (araddr),
        .s_arvalid (arvalid),
        .s_arready (arready),
        .s_rdata   (rdata),
        .s_rresp   (rresp),
        .s_rvalid  (rvalid),
        .s_rready  (1'b1)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; accepted on the next rising edge; returns at the following falling edge.
    task automatic axi_wr(input logic [11:0] a, input logic [31:0] d);
        awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
    endtask

    task automatic axi_rd(input logic [11:0] a, output logic [31:0] d, output logic [1:0] r);
        araddr = a; arvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        d = rdata; r = rresp;
    endtask

    function automatic logic [31:0] kw(input logic [255:0] k, input int i);
        return k[i*32 +: 32];
    endfunction

    // Load the masked words (one possibly corrupted), start, probe edges 34 and 35, read the verdict.
    task automatic run_cmp(input logic [7:0] mask, input int bad, input logic [255:0] k,
                           input logic exp, input string req);
        logic [31:0] d;
        logic [1:0]  r;
        for (int i = 0; i < 8; i++)
            if (mask[i]) axi_wr(A_KEY + 12'(4 * i), kw(k, i) ^ ((i == bad) ? (32'h1 << (i * 3)) : 32'h0));
        axi_wr(A_CTRL, 32'h1);
        repeat (33) @(negedge clk);
        axi_rd(A_CTRL, d, r);
        check(d == 32'h0, "R5 busy at edge 34", d, 32'h0);
        axi_rd(A_CTRL, d, r);
        check(d == 32'h6, "R5 done at edge 35", d, 32'h6);
        axi_rd(A_CTRL, d, r);
        check(d == 32'h4, "R6 done cleared by read", d, 32'h4);
        axi_rd(A_RES, d, r);
        check(d == {31'b0, exp}, req, d, {31'b0, exp});
    endtask

    initial begin
        logic [31:0] d;
        logic [1:0]  r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        axi_rd(A_CTRL, d, r);
        check(d == 32'h4, "R1 control after reset", d, 32'h4);
        axi_rd(A_RES, d, r);
        check(d == 32'h0, "R1 verdict after reset", d, 32'h0);

        // R4 empty key
        run_cmp(8'h00, -1, TB_KEY, 1'b0, "R4 empty key");
        // R2 full match
        run_cmp(8'hFF, -1, TB_KEY, 1'b1, "R2 full match");
        // R4 restart without rewriting
        run_cmp(8'h00, -1, TB_KEY, 1'b0, "R4 restart without rewrite");
        // R3 one corrupted word at every position
        for (int w = 0; w < 8; w++) run_cmp(8'hFF, w, TB_KEY, 1'b0, "R3 corrupted word");
        // R4 one missing word at every position (stored value is correct, flag is not)
        for (int w = 0; w < 8; w++) begin
            run_cmp(8'hFF, -1, TB_KEY, 1'b1, "R2 match before omission");
            run_cmp(~(8'h1 << w), -1, TB_KEY, 1'b0, "R4 missing word");
        end
        // R3 all-zero candidate
        run_cmp(8'hFF, -1, 256'h0, 1'b0, "R3 zero key");
        // R2 word order: swapped halves must fail
        run_cmp(8'hFF, -1, {TB_KEY[127:0], TB_KEY[255:128]}, 1'b0, "R2 word order");

        // R8 candidate region and unmapped reads return zero with OKAY
        for (int i = 0; i < 8; i++) axi_wr(A_KEY + 12'(4 * i), kw(TB_KEY, i));
        for (int i = 0; i < 8; i++) begin
            axi_rd(A_KEY + 12'(4 * i), d, r);
            check(d == 32'h0 && r == 2'b00, "R8 key word reads zero", {r, d[29:0]}, 32'h0);
        end
        axi_rd(12'h004, d, r); check(d == 0 && r == 0, "R8 unmapped 0x004", d, 32'h0);
        axi_rd(12'h0A0, d, r); check(d == 0 && r == 0, "R8 unmapped 0x0A0", d, 32'h0);
        axi_rd(12'h104, d, r); check(d == 0 && r == 0, "R8 unmapped 0x104", d, 32'h0);
        axi_rd(12'h101, d, r); check(d == 0 && r == 0, "R8 misaligned 0x101", d, 32'h0);
        axi_rd(12'hFFC, d, r); check(d == 0 && r == 0, "R8 unmapped 0xFFC", d, 32'h0);

        // R7 start while busy is ignored (words already loaded above)
        axi_wr(A_CTRL, 32'h1);
        repeat (9) @(negedge clk);
        axi_wr(A_CTRL, 32'h1);
        axi_wr(A_KEY, 32'h0);
        repeat (22) @(negedge clk);
        axi_rd(A_CTRL, d, r);
        check(d == 32'h0, "R7 still busy at edge 34", d, 32'h0);
        axi_rd(A_CTRL, d, r);
        check(d == 32'h6, "R7 completion edge unchanged", d, 32'h6);
        axi_rd(A_RES, d, r);
        check(d == 32'h1, "R7 busy key write ignored", d, 32'h1);

        // R6 start clears done; R9 start clears verdict
        for (int i = 0; i < 8; i++) axi_wr(A_KEY + 12'(4 * i), kw(TB_KEY, i));
        axi_wr(A_CTRL, 32'h1);
        repeat (40) @(negedge clk);
        axi_rd(A_RES, d, r);
        check(d == 32'h1, "R2 verdict before restart", d, 32'h1);
        axi_wr(A_CTRL, 32'h1);
        axi_rd(A_CTRL, d, r);
        check(d == 32'h0, "R6 start clears done", d, 32'h0);
        axi_rd(A_RES, d, r);
        check(d == 32'h0, "R9 verdict cleared while busy", d, 32'h0);
        repeat (40) @(negedge clk);
        axi_rd(A_CTRL, d, r);
        check(d == 32'h6, "R6 done after second run", d, 32'h6);
        axi_rd(A_RES, d, r);
        check(d == 32'h0, "R4 second run without rewrite", d, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule